// File: doc/BRIEF.md
# Fuse Array Read Controller

The block lets software read a small one-time-programmable fuse array through a register port. The array holds 32 blocks of 16 bits, 64 bytes in all. Software picks a block, issues a read command, waits for a sticky completion flag, fetches the latched word and then clears the flag. The fuse contents come from a behavioural model that stands in for the sensing circuit. Burn cycles exist only as a busy bit driven by a programmable timer.

The controller runs only while an external module-enable input is high. Dropping that input aborts any cycle in progress. Commands are accepted only in standby. Standby means the enable is high and neither a read nor a burn is under way. Register reads are combinational from the address. Register writes take effect on the rising clock edge.

Top module: `fuse_read_ctrl`

## Requirements
- R1: After reset every storage register reads 0. The status register reads 0x04 (standby only) while module enable is high, and 0x00 while it is low.
- R2: The block-index register (offset 0x0C) keeps only bits 4:0. Writing 0xFF reads back 0x1F.
- R3: The command register (offset 0x10) always reads 0. Its bit 1 starts a read, bit 0 starts a burn and bit 2 clears the read-done flag.
- R4: A read started in standby holds status bit 1 (read busy) high, and bit 2 (standby) low, for exactly T cycles. T is the read-timing register (offset 0x24), with 0 taken as 1. Afterwards the status reads 0x14 (standby and done).
- R5: Block i holds ((i * 0x0F1D) XOR 0xA55A) mod 2^16. The read-data register (offset 0x04) returns that word zero-extended, for the index captured when the read started. It keeps the value until the next read completes.
- R6: The read-done flag (status bit 4) stays set until a command write with bit 2 set clears it.
- R7: A read command is ignored while module enable is low or while a cycle is running. Flags, timing and the captured index stay unchanged.
- R8: A burn command in standby holds status bit 0 high, and standby low, for W cycles. W is the write-timing register (offset 0x20), with 0 taken as 1. Bit 0 of the global control register (offset 0x00) shows as status bit 3 (protection). While it is set, burn commands are ignored. A burn never changes the read data.
- R9: Dropping module enable clears both busy bits by the next cycle. It keeps the done flag as it was and leaves the read data unchanged.
- R10: Status layout: bit 0 burn busy, bit 1 read busy, bit 2 standby, bit 3 protection, bit 4 done. The two busy bits are never set together.
- R11: The write-data (0x08) and debounce (0x28) registers store all 32 bits. Global control keeps only bit 0. Both timing registers keep 16 bits. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| moduleEn | input | 1 | Module enable; low aborts and blocks all cycles |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |

## Verification
The bench counts the busy window cycle by cycle for timing values of 0, 1 and larger. A design with an off-by-one counter, or one that treats zero as a huge count, shows up at once. The bench retargets the index and re-issues the start in the middle of a read. A controller that restarts or re-samples the index would return the wrong block or stretch the window. The bench drops the enable during a read that follows a completed one. A design that clears done on abort, or latches partial data, fails the check on the kept flag and word. Protected burns and the clear command close the set.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

  localparam int unsigned OFF_GLB   = 'h00;
  localparam int unsigned OFF_RDATA = 'h04;
  localparam int unsigned OFF_WDATA = 'h08;
  localparam int unsigned OFF_INDEX = 'h0C;
  localparam int unsigned OFF_MODE  = 'h10;
  localparam int unsigned OFF_STAT  = 'h14;
  localparam int unsigned OFF_WTIM  = 'h20;
  localparam int unsigned OFF_RTIM  = 'h24;
  localparam int unsigned OFF_DEB   = 'h28;

  localparam int unsigned MODE_PG_BIT  = 0;
  localparam int unsigned MODE_RD_BIT  = 1;
  localparam int unsigned MODE_CLR_BIT = 2;

  localparam int unsigned ST_PGBUSY_BIT = 0;
  localparam int unsigned ST_RDBUSY_BIT = 1;
  localparam int unsigned ST_STANDBY_BIT = 2;
  localparam int unsigned ST_PROT_BIT   = 3;
  localparam int unsigned ST_DONE_BIT   = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_PROG = 2'd2
  } ctlState_t;

  // requests decoded from the register port
  typedef struct packed {
    logic rdStart;
    logic pgStart;
  } cmd_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureIdx;
    logic latchData;
    logic setDone;
  } strobe_t;

endpackage

// File: rtl/fuse_array_model.sv
module fuse_array_model #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned BLK_W = 16,
  parameter logic [BLK_W-1:0] FUSE_MUL = 16'h0F1D,
  parameter logic [BLK_W-1:0] FUSE_XOR = 16'hA55A
) (
  input  logic [IDX_W-1:0] blkIdx,
  output logic [BLK_W-1:0] blkData
);

  logic [BLK_W-1:0] idxExt;
  logic [BLK_W-1:0] product;

  assign idxExt  = BLK_W'(blkIdx);
  assign product = idxExt * FUSE_MUL;
  assign blkData = product ^ FUSE_XOR;

endmodule

// File: rtl/fuse_rd_control.sv
module fuse_rd_control
  import fuse_rd_pkg::*;
#(
  parameter int unsigned TIM_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             moduleEn,
  input  cmd_t             cmd,
  input  logic [TIM_W-1:0] rdTiming,
  input  logic [TIM_W-1:0] wrTiming,
  input  logic             protect,
  output strobe_t          strobe,
  output logic             rdBusy,
  output logic             pgBusy,
  output logic             standby
);

  ctlState_t        state;
  logic [TIM_W-1:0] cnt;
  logic             lastCycle;
  logic             acceptRd;
  logic             acceptPg;

  function automatic logic [TIM_W-1:0] loadVal(input logic [TIM_W-1:0] t);
    return (t == '0) ? TIM_W'(1) : t;
  endfunction

  assign standby   = moduleEn && (state == ST_IDLE);
  assign acceptRd  = standby && cmd.rdStart;
  assign acceptPg  = standby && cmd.pgStart && !cmd.rdStart && !protect;
  assign lastCycle = (cnt <= TIM_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (!moduleEn) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (acceptRd) begin
            state <= ST_READ;
            cnt   <= loadVal(rdTiming);
          end else if (acceptPg) begin
            state <= ST_PROG;
            cnt   <= loadVal(wrTiming);
          end
        end
        ST_READ, ST_PROG: begin
          if (lastCycle) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt - TIM_W'(1);
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.captureIdx = acceptRd;
    strobe.latchData  = moduleEn && (state == ST_READ) && lastCycle;
    strobe.setDone    = moduleEn && (state == ST_READ) && lastCycle;
  end

  assign rdBusy = (state == ST_READ);
  assign pgBusy = (state == ST_PROG);

endmodule

// File: rtl/fuse_rd_datapath.sv
module fuse_rd_datapath
  import fuse_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned BLK_W  = 16,
  parameter int unsigned TIM_W  = 16,
  parameter logic [BLK_W-1:0] FUSE_MUL = 16'h0F1D,
  parameter logic [BLK_W-1:0] FUSE_XOR = 16'hA55A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  strobe_t           strobe,
  input  logic              rdBusy,
  input  logic              pgBusy,
  input  logic              standby,
  output cmd_t              cmd,
  output logic [TIM_W-1:0]  rdTiming,
  output logic [TIM_W-1:0]  wrTiming,
  output logic              protect,
  output logic              doneFlag,
  output logic [BLK_W-1:0]  rdData
);

  logic [DATA_W-1:0] wrDataReg;
  logic [DATA_W-1:0] debReg;
  logic [IDX_W-1:0]  idxReg;
  logic [IDX_W-1:0]  curIdx;
  logic [BLK_W-1:0]  fuseWord;
  logic [DATA_W-1:0] statusWord;

  logic wrGlb, wrWdata, wrIdx, wrMode, wrWtim, wrRtim, wrDeb;

  assign wrGlb   = regWrEn && (regAddr == ADDR_W'(OFF_GLB));
  assign wrWdata = regWrEn && (regAddr == ADDR_W'(OFF_WDATA));
  assign wrIdx   = regWrEn && (regAddr == ADDR_W'(OFF_INDEX));
  assign wrMode  = regWrEn && (regAddr == ADDR_W'(OFF_MODE));
  assign wrWtim  = regWrEn && (regAddr == ADDR_W'(OFF_WTIM));
  assign wrRtim  = regWrEn && (regAddr == ADDR_W'(OFF_RTIM));
  assign wrDeb   = regWrEn && (regAddr == ADDR_W'(OFF_DEB));

  always_comb begin
    cmd         = '0;
    cmd.rdStart = wrMode && regWrData[MODE_RD_BIT];
    cmd.pgStart = wrMode && regWrData[MODE_PG_BIT];
  end

  fuse_array_model #(
    .IDX_W   (IDX_W),
    .BLK_W   (BLK_W),
    .FUSE_MUL(FUSE_MUL),
    .FUSE_XOR(FUSE_XOR)
  ) uFuse (
    .blkIdx (curIdx),
    .blkData(fuseWord)
  );

  // configuration storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      protect   <= 1'b0;
      wrDataReg <= '0;
      idxReg    <= '0;
      wrTiming  <= '0;
      rdTiming  <= '0;
      debReg    <= '0;
    end else begin
      if (wrGlb)   protect   <= regWrData[0];
      if (wrWdata) wrDataReg <= regWrData;
      if (wrIdx)   idxReg    <= regWrData[IDX_W-1:0];
      if (wrWtim)  wrTiming  <= regWrData[TIM_W-1:0];
      if (wrRtim)  rdTiming  <= regWrData[TIM_W-1:0];
      if (wrDeb)   debReg    <= regWrData;
    end
  end

  // read path state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx   <= '0;
      rdData   <= '0;
      doneFlag <= 1'b0;
    end else begin
      if (strobe.captureIdx) curIdx <= idxReg;
      if (strobe.latchData)  rdData <= fuseWord;
      if (strobe.setDone)
        doneFlag <= 1'b1;
      else if (wrMode && regWrData[MODE_CLR_BIT])
        doneFlag <= 1'b0;
    end
  end

  always_comb begin
    statusWord                 = '0;
    statusWord[ST_PGBUSY_BIT]  = pgBusy;
    statusWord[ST_RDBUSY_BIT]  = rdBusy;
    statusWord[ST_STANDBY_BIT] = standby;
    statusWord[ST_PROT_BIT]    = protect;
    statusWord[ST_DONE_BIT]    = doneFlag;
  end

  always_comb begin
    case (regAddr)
      ADDR_W'(OFF_GLB):   regRdData = DATA_W'(protect);
      ADDR_W'(OFF_RDATA): regRdData = DATA_W'(rdData);
      ADDR_W'(OFF_WDATA): regRdData = wrDataReg;
      ADDR_W'(OFF_INDEX): regRdData = DATA_W'(idxReg);
      ADDR_W'(OFF_STAT):  regRdData = statusWord;
      ADDR_W'(OFF_WTIM):  regRdData = DATA_W'(wrTiming);
      ADDR_W'(OFF_RTIM):  regRdData = DATA_W'(rdTiming);
      ADDR_W'(OFF_DEB):   regRdData = debReg;
      default:            regRdData = '0;
    endcase
  end

endmodule

// File: rtl/fuse_read_ctrl.sv
module fuse_read_ctrl
  import fuse_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned BLK_W  = 16,
  parameter int unsigned TIM_W  = 16,
  parameter logic [BLK_W-1:0] FUSE_MUL = 16'h0F1D,
  parameter logic [BLK_W-1:0] FUSE_XOR = 16'hA55A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              moduleEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);

  cmd_t             cmd;
  strobe_t          strobe;
  logic [TIM_W-1:0] rdTiming;
  logic [TIM_W-1:0] wrTiming;
  logic             protect;
  logic             rdBusy;
  logic             pgBusy;
  logic             standby;
  logic             doneFlag;
  logic [BLK_W-1:0] rdData;

  fuse_rd_control #(.TIM_W(TIM_W)) uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .moduleEn(moduleEn),
    .cmd     (cmd),
    .rdTiming(rdTiming),
    .wrTiming(wrTiming),
    .protect (protect),
    .strobe  (strobe),
    .rdBusy  (rdBusy),
    .pgBusy  (pgBusy),
    .standby (standby)
  );

  fuse_rd_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W),
    .BLK_W   (BLK_W),
    .TIM_W   (TIM_W),
    .FUSE_MUL(FUSE_MUL),
    .FUSE_XOR(FUSE_XOR)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .strobe   (strobe),
    .rdBusy   (rdBusy),
    .pgBusy   (pgBusy),
    .standby  (standby),
    .cmd      (cmd),
    .rdTiming (rdTiming),
    .wrTiming (wrTiming),
    .protect  (protect),
    .doneFlag (doneFlag),
    .rdData   (rdData)
  );

endmodule

// File: rtl/fuse_read_ctrl_chk.sv
module fuse_read_ctrl_chk #(
  parameter int unsigned BLK_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             moduleEn,
  input logic             clrCmd,
  input logic             rdBusy,
  input logic             pgBusy,
  input logic             doneFlag,
  input logic [BLK_W-1:0] rdData
);

  // R9: enable low ends any cycle by the next edge
  p_abort_clears_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    !moduleEn |=> (!rdBusy && !pgBusy));

  // R6: done holds unless a clear command arrives
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !clrCmd) |=> doneFlag);

  // R4: done rises only at the end of a read
  p_done_after_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(rdBusy));

  // R5: read data changes only as a read finishes
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> $past(rdBusy));

  // R10: busy bits are exclusive
  p_busy_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(rdBusy && pgBusy));

  // R7: a read can begin only under enable
  p_start_needs_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdBusy) |-> $past(moduleEn));

endmodule

bind fuse_read_ctrl fuse_read_ctrl_chk #(.BLK_W(BLK_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .moduleEn(moduleEn),
  .clrCmd  (regWrEn && (regAddr == ADDR_W'(fuse_rd_pkg::OFF_MODE)) && regWrData[2]),
  .rdBusy  (rdBusy),
  .pgBusy  (pgBusy),
  .doneFlag(doneFlag),
  .rdData  (rdData)
);

// File: tb/fuse_read_ctrl_test.sv
`timescale 1ns/1ps
module fuse_read_ctrl_test;

  localparam int A_GLB = 'h00, A_RDATA = 'h04, A_WDATA = 'h08, A_INDEX = 'h0C;
  localparam int A_MODE = 'h10, A_STAT = 'h14, A_WTIM = 'h20, A_RTIM = 'h24, A_DEB = 'h28;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        moduleEn = 1'b1;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  fuse_read_ctrl uut (
    .clk(clk), .rstN(rstN), .moduleEn(moduleEn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  function automatic logic [31:0] fuseExp(input int i);
    logic [31:0] p;
    p = (i * 32'h0F1D) ^ 32'hA55A;
    return {16'h0, p[15:0]};
  endfunction

  function automatic int timEff(input int t);
    return (t == 0) ? 1 : t;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input int off, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 8'(off); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input int off, output logic [31:0] v);
    regAddr = 8'(off);
    #1;
    v = regRdData;
  endtask

  task automatic countBusy(input int bitPos, output int cnt);
    logic [31:0] st;
    cnt = 0;
    for (int i = 0; i < 1000; i++) begin
      rdReg(A_STAT, st);
      if (!st[bitPos]) break;
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic doRead(input logic [31:0] idxRaw, input int tim, input bit clearAfter);
    logic [31:0] v;
    int cnt;
    wrReg(A_RTIM, 32'(tim));
    wrReg(A_INDEX, idxRaw);
    wrReg(A_MODE, 32'h2);
    countBusy(1, cnt);
    chk("R4 busy cycles", 32'(cnt), 32'(timEff(tim)));
    rdReg(A_STAT, v);
    chk("R4 status after read", v, 32'h14);
    rdReg(A_RDATA, v);
    chk("R5 read data", v, fuseExp(int'(idxRaw[4:0])));
    if (clearAfter) begin
      wrReg(A_MODE, 32'h4);
      rdReg(A_STAT, v);
      chk("R6 clear done", v, 32'h04);
    end
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cnt;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(A_STAT, v);   chk("R1 status", v, 32'h04);
    rdReg(A_RDATA, v);  chk("R1 rdata", v, 32'h0);
    rdReg(A_INDEX, v);  chk("R1 index", v, 32'h0);
    rdReg(A_RTIM, v);   chk("R1 rtim", v, 32'h0);
    moduleEn = 1'b0;
    rdReg(A_STAT, v);   chk("R1 status enable low", v, 32'h0);
    moduleEn = 1'b1;

    // R2 index mask, R3 command reads 0, R11 storage
    wrReg(A_INDEX, 32'hFF); rdReg(A_INDEX, v); chk("R2 index mask", v, 32'h1F);
    wrReg(A_MODE, 32'h4);   rdReg(A_MODE, v);  chk("R3 mode reads zero", v, 32'h0);
    wrReg(A_DEB, 32'h1234ABCD); rdReg(A_DEB, v); chk("R11 debounce", v, 32'h1234ABCD);
    wrReg(A_WDATA, 32'hFFFF0001); rdReg(A_WDATA, v); chk("R11 write data", v, 32'hFFFF0001);
    wrReg(A_GLB, 32'hFE); rdReg(A_GLB, v); chk("R11 global ctrl", v, 32'h0);
    wrReg(A_RTIM, 32'hABCDE); rdReg(A_RTIM, v); chk("R11 rtim width", v, 32'hBCDE);
    rdReg('h30, v); chk("R11 unmapped", v, 32'h0);

    // R4/R5 directed timing corners
    doRead(32'd0, 0, 1'b1);
    doRead(32'd31, 1, 1'b1);
    doRead(32'hE5, 7, 1'b0);
    // R6 done persists
    repeat (5) @(negedge clk);
    rdReg(A_STAT, v); chk("R6 done sticky", v, 32'h14);
    wrReg(A_MODE, 32'h4);

    // R7 start ignored with enable low
    wrReg(A_INDEX, 32'd4);
    moduleEn = 1'b0;
    wrReg(A_MODE, 32'h2);
    rdReg(A_STAT, v); chk("R7 start enable low", v, 32'h0);
    moduleEn = 1'b1;
    @(negedge clk);
    rdReg(A_STAT, v); chk("R7 still standby", v, 32'h04);

    // R7 retarget and restart during a read
    wrReg(A_RTIM, 32'd10);
    wrReg(A_INDEX, 32'd3);
    wrReg(A_MODE, 32'h2);
    cnt = 0;
    for (int i = 0; i < 1000; i++) begin
      rdReg(A_STAT, v);
      if (!v[1]) break;
      cnt++;
      if (cnt == 2) begin
        regWrEn = 1'b1; regAddr = 8'(A_INDEX); regWrData = 32'd9;
      end else if (cnt == 3) begin
        regWrEn = 1'b1; regAddr = 8'(A_MODE); regWrData = 32'h2;
      end
      @(negedge clk);
      regWrEn = 1'b0;
    end
    chk("R7 busy unaffected", 32'(cnt), 32'd10);
    rdReg(A_RDATA, v); chk("R7 original index", v, fuseExp(3));
    wrReg(A_MODE, 32'h4);

    // R8 burn timing and protection
    wrReg(A_WTIM, 32'd5);
    wrReg(A_MODE, 32'h1);
    rdReg(A_STAT, v); chk("R8 burn status", v, 32'h01);
    countBusy(0, cnt);
    chk("R8 burn cycles", 32'(cnt), 32'd5);
    rdReg(A_RDATA, v); chk("R8 data untouched", v, fuseExp(3));
    wrReg(A_GLB, 32'h1);
    rdReg(A_STAT, v); chk("R8 protect bit", v, 32'h0C);
    wrReg(A_MODE, 32'h1);
    rdReg(A_STAT, v); chk("R8 burn blocked", v, 32'h0C);
    wrReg(A_GLB, 32'h0);

    // R9 abort keeps done and data
    doRead(32'd7, 2, 1'b0);
    wrReg(A_RTIM, 32'd20);
    wrReg(A_INDEX, 32'd5);
    wrReg(A_MODE, 32'h2);
    repeat (3) @(negedge clk);
    moduleEn = 1'b0;
    @(negedge clk);
    rdReg(A_STAT, v); chk("R9 abort status", v, 32'h10);
    moduleEn = 1'b1;
    repeat (25) @(negedge clk);
    rdReg(A_STAT, v); chk("R9 after reenable", v, 32'h14);
    rdReg(A_RDATA, v); chk("R9 data kept", v, fuseExp(7));
    wrReg(A_MODE, 32'h4);

    // random reads (R4, R5)
    for (int k = 0; k < 30; k++) begin
      logic [31:0] idxRaw;
      int tim;
      idxRaw = $urandom();
      tim = int'($urandom_range(0, 6));
      doRead(idxRaw, tim, ($urandom_range(0, 1) == 1));
      wrReg(A_MODE, 32'h4);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule